// File: doc/BRIEF.md
# Transmit Queue Grant Arbiter

This block decides which of eight transmit queues owns the shared transmit path. Each queue raises a request flag while it has a packet waiting. It also raises a last-fragment flag while the fragment it is offering ends its packet. The transmit path pulses an accept input each time it takes a fragment from the queue that holds the grant.

A mode input selects how the next owner is chosen. In fixed-priority mode the highest-numbered requesting queue always wins. In rotating mode every queue has equal weight, and the search begins at the queue after the last one served. A grant, once given, covers the whole packet, however many fragments it spans. It is released only when the owner's last fragment is accepted.

The block drives a one-hot grant vector, the encoded number of the owning queue and a valid flag.

Top module: `tx_queue_arbiter`

## Requirements
- R1: The grant vector has at most one bit set. While the valid flag is high, bit `grant_ch_o` of the grant vector is the only bit set. While the valid flag is low, the grant vector is zero and `grant_ch_o` is 0.
- R2: When no grant is active and at least one request bit is high at a clock edge, the valid flag rises after that edge. The granted queue is one whose request bit was high at that edge.
- R3: With `mode_rr_i` = 0 (fixed priority), the grant goes to the highest-numbered requesting queue. Queue 7 is the highest and queue 0 the lowest.
- R4: With `mode_rr_i` = 1 (rotation), the grant goes to the first requesting queue found by counting upward from the last granted queue plus one, wrapping from 7 to 0.
- R5: While a grant is active, it stays on the same queue across any number of accepted fragments that are not the last. Changes to any request bit, including the owner's, do not move it.
- R6: An edge with `accept_i` high and the owner's bit of `eop_i` high ends the grant: the valid flag is low after that edge. The next grant follows one edge later at the earliest. The `eop_i` bits of queues that do not own the grant have no effect.
- R7: The mode input is used only in a cycle with no active grant. Changing it while a grant is active has no effect on that grant. The new mode decides the next arbitration.
- R8: With no request high and no grant active, the block stays idle. An `accept_i` pulse while idle has no effect.
- R9: After reset no grant is active. The rotation search starts from queue 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr_i | input | 1 | 1 = rotating equal priority, 0 = fixed priority |
| req_i | input | 8 | Per-queue packet-waiting flag |
| eop_i | input | 8 | Per-queue flag: the offered fragment ends the packet |
| accept_i | input | 1 | Transmit path takes a fragment from the owner |
| grant_o | output | 8 | One-hot owner of the transmit path |
| grant_ch_o | output | 3 | Encoded owner number |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The hardest case to reach is a mode change that lands in the middle of a packet. The stimulus has to show that the change is ignored for the packet in progress and applied at the next arbitration. The bench first lets fixed priority grant queue 7 and switches to rotation while that grant is held. After the release it presents the same request pattern, queues 0 and 7. Fixed priority would pick 7 again and rotation picks 0, so the grant shows which mode was in effect. Hold behaviour is pressed by accepting several non-final fragments, raising the last-fragment flag of a queue that does not own the grant, and withdrawing all requests while a packet is in flight.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/tx_arb_fixed_pick.sv
// Highest-numbered requesting queue wins.
module tx_arb_fixed_pick #(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic              hit_o,
    output logic [CW-1:0]     idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = CW'(i);
            end
        end
    end
endmodule

// File: rtl/tx_arb_rotate_pick.sv
// First requesting queue after the last one served, wrapping around.
module tx_arb_rotate_pick #(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [CW-1:0]     last_i,
    output logic              hit_o,
    output logic [CW-1:0]     idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int j;
            j = int'(last_i) + k;
            if (j >= NUM_CH) j = j - NUM_CH;
            if (!hit_o && req_i[j]) begin
                hit_o = 1'b1;
                idx_o = CW'(j);
            end
        end
    end
endmodule

// File: rtl/tx_queue_arbiter.sv
module tx_queue_arbiter #(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rr_i,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] eop_i,
    input  logic              accept_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [CW-1:0]     grant_ch_o,
    output logic              grant_valid_o
);
    import tx_arb_pkg::*;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] ch;
        logic [CW-1:0] last;
    } arb_state_t;

    arb_state_t st_d, st_q;
    arb_mode_e  mode;
    logic       fx_hit_d, rr_hit_d;
    logic [CW-1:0] fx_idx_d, rr_idx_d, pick_d;
    logic       any_req_d;

    assign mode = arb_mode_e'(mode_rr_i);

    tx_arb_fixed_pick #(.NUM_CH(NUM_CH)) u_fixed (
        .req_i (req_i),
        .hit_o (fx_hit_d),
        .idx_o (fx_idx_d)
    );

    tx_arb_rotate_pick #(.NUM_CH(NUM_CH)) u_rotate (
        .req_i  (req_i),
        .last_i (st_q.last),
        .hit_o  (rr_hit_d),
        .idx_o  (rr_idx_d)
    );

    always_comb begin
        st_d      = st_q;
        any_req_d = (mode == ARB_ROUND) ? rr_hit_d : fx_hit_d;
        pick_d    = (mode == ARB_ROUND) ? rr_idx_d : fx_idx_d;
        if (st_q.active) begin
            // Owner keeps the path until its last fragment is taken.
            if (accept_i && eop_i[st_q.ch]) begin
                st_d.active = 1'b0;
                st_d.ch     = '0;
            end
        end else if (any_req_d) begin
            st_d.active = 1'b1;
            st_d.ch     = pick_d;
            st_d.last   = pick_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.ch     <= '0;
            st_q.last   <= CW'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        grant_o = '0;
        if (st_q.active) grant_o[st_q.ch] = 1'b1;
    end
    assign grant_ch_o    = st_q.ch;
    assign grant_valid_o = st_q.active;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)) else $error("grant not one-hot"); // R1
    AST_CH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> grant_o[grant_ch_o]) else $error("channel mismatch"); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> (grant_o == '0)) else $error("idle grant nonzero"); // R8
    AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && (req_i != '0)) |=> (grant_valid_o && ((grant_o & $past(req_i)) != '0)))
        else $error("grant missing or not to requester"); // R2
    AST_HOLD_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !(accept_i && eop_i[grant_ch_o])) |=> $stable(grant_o))
        else $error("grant moved mid-packet"); // R5
    AST_RELEASE_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && accept_i && eop_i[grant_ch_o]) |=> !grant_valid_o)
        else $error("grant not released"); // R6
endmodule

// File: tb/tb_tx_queue_arbiter.sv
`timescale 1ns/1ps
module tb_tx_queue_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rr_i = 1'b0;
    logic [7:0] req_i = '0;
    logic [7:0] eop_i = '0;
    logic       accept_i = 1'b0;
    logic [7:0] grant_o;
    logic [2:0] grant_ch_o;
    logic       grant_valid_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    tx_queue_arbiter dut (
        .clk(clk), .rst_n(rst_n), .mode_rr_i(mode_rr_i), .req_i(req_i),
        .eop_i(eop_i), .accept_i(accept_i), .grant_o(grant_o),
        .grant_ch_o(grant_ch_o), .grant_valid_o(grant_valid_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic ev, input int ech);
        logic [7:0] eg;
        int ec;
        eg = ev ? (8'd1 << ech) : 8'd0;
        ec = ev ? ech : 0;
        checks++;
        if (grant_valid_o !== ev || grant_o !== eg || int'(grant_ch_o) != ec) begin
            failures++;
            $display("FAIL %s: valid=%0b grant=%b ch=%0d expected valid=%0b grant=%b ch=%0d",
                     tag, grant_valid_o, grant_o, grant_ch_o, ev, eg, ec);
        end
    endtask

    task automatic do_reset();
        req_i = '0; eop_i = '0; accept_i = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Accept the owner's last fragment; grant drops on the next edge.
    task automatic release_pkt(input string tag, input int ch);
        accept_i = 1'b1;
        eop_i = 8'd1 << ch;
        tick();
        accept_i = 1'b0;
        eop_i = '0;
        chk(tag, 1'b0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 reset idle", 1'b0, 0);
        accept_i = 1'b1;
        tick();
        tick();
        accept_i = 1'b0;
        chk("R8 accept while idle", 1'b0, 0);
    endtask

    task automatic t_fixed();
        do_reset();
        mode_rr_i = 1'b0;
        req_i = 8'b1010_0101;
        tick();
        chk("R3 fixed picks 7", 1'b1, 7);
        release_pkt("R6 release 7", 7);
        req_i = 8'b0010_0101;
        tick();
        chk("R3 fixed picks 5", 1'b1, 5);
        release_pkt("R6 release 5", 5);
        req_i = 8'b0000_0001;
        tick();
        chk("R2 fixed lone 0", 1'b1, 0);
        req_i = '0;
        release_pkt("R6 release 0", 0);
        tick();
        chk("R8 no request idle", 1'b0, 0);
    endtask

    task automatic t_rotate();
        do_reset();
        mode_rr_i = 1'b1;
        req_i = 8'hFF;
        tick();
        chk("R9 rotate starts at 0", 1'b1, 0);
        release_pkt("R6 release 0", 0);
        tick();
        chk("R4 rotate next 1", 1'b1, 1);
        req_i = 8'h81;
        release_pkt("R6 release 1", 1);
        tick();
        chk("R4 rotate skips to 7", 1'b1, 7);
        release_pkt("R6 release 7", 7);
        tick();
        chk("R4 rotate wraps to 0", 1'b1, 0);
        req_i = '0;
        release_pkt("R6 release 0b", 0);
    endtask

    task automatic t_hold();
        do_reset();
        mode_rr_i = 1'b0;
        req_i = 8'h08;
        tick();
        chk("R2 grant 3", 1'b1, 3);
        req_i = 8'hFF;
        accept_i = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        chk("R5 hold over fragments", 1'b1, 3);
        eop_i = 8'h80;
        tick();
        chk("R6 foreign eop ignored", 1'b1, 3);
        accept_i = 1'b0;
        eop_i = 8'h08;
        tick();
        chk("R6 eop without accept", 1'b1, 3);
        eop_i = '0;
        req_i = '0;
        tick();
        tick();
        chk("R5 request withdrawn", 1'b1, 3);
        release_pkt("R6 release 3", 3);
    endtask

    task automatic t_mode();
        do_reset();
        mode_rr_i = 1'b0;
        req_i = 8'h81;
        tick();
        chk("R3 fixed picks 7", 1'b1, 7);
        mode_rr_i = 1'b1;
        tick();
        tick();
        chk("R7 mode change mid-packet", 1'b1, 7);
        release_pkt("R6 release 7", 7);
        tick();
        chk("R7 new mode rotates to 0", 1'b1, 0);
        release_pkt("R6 release 0", 0);
        mode_rr_i = 1'b0;
        tick();
        chk("R7 back to fixed picks 7", 1'b1, 7);
        req_i = '0;
        release_pkt("R6 release 7b", 7);
    endtask

    initial begin
        t_reset();
        t_fixed();
        t_rotate();
        t_hold();
        t_mode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule